// File: doc/BRIEF.md
# Phase-Continuous FSK Tone Synthesizer

This block turns a serial transmit bit into a square-wave frequency-shift-keyed tone derived from one fixed master clock. A logic one on the data input produces the mark tone and a logic zero the space tone. The data may change at any instant. A phase accumulator advances by a tuning word on every master clock cycle, and its top bit is the tone. A data change only swaps the tuning word, so the waveform carries on from the phase it had reached and never restarts.

Three mode inputs select the signalling standard, the transmit speed and the tone pair. One of them, the standard-select input, is either held at a level or driven with a toggling divided clock. The block itself detects which of these it is. The block also produces a bit-rate reference clock at sixteen times the fastest transmit or receive rate of the selected mode, taken as a fixed division of the master clock. One mode switches the transmitter off and holds the tone low.

Top module: `fsk_tone_synth`

## Requirements
- R1: While reset is high and on the first clock after it, `tone_o`, `ref_clk_o` and `tx_en_o` are 0.
- R2: With the select input static (level s) and inputs {s,r1,r2}, the tone (data 1 / data 0) is: 000 and 100 give 1300/2100 Hz, 001 and 101 give 1300/1700 Hz, and 010, 110 and 011 give 390/450 Hz. Each period is within 0.5 % of CLK_HZ divided by the tone frequency.
- R3: With the select input toggling, r1=0 gives 1200/2200 Hz and r1=1 gives 387/487 Hz, whatever the value of r2, within 0.5 %.
- R4: Inputs {s,r1,r2}=111 with a static select input drive `tx_en_o` to 0 and hold `tone_o` at 0 whatever the data. Every other mode drives `tx_en_o` to 1.
- R5: The full `ref_clk_o` period in master cycles is 232 for static 000, 100, 010, 111 and for toggling r1r2 = 00, 01, 10. It is 464 for static 001, 101, 110, 3712 for static 011 and 1856 for toggling r1r2=11.
- R6: `tx_data_i` passes through a two-flop synchronizer before it selects mark (1) or space (0).
- R7: A data change alters the tuning word only. The accumulator phase is kept, so no high or low run of `tone_o` is shorter than the half period of the faster tone minus one cycle, or longer than the half period of the slower tone plus one.
- R8: The select input counts as toggling once two transitions occur less than STD_WIN cycles apart. It returns to level decoding after STD_WIN cycles without a transition. A single transition does not make it count as toggling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (nominal CLK_HZ) |
| rst | input | 1 | Synchronous active-high reset |
| mode_std_i | input | 1 | Standard select: static level or toggling divided clock |
| mode_r1_i | input | 1 | Rate select bit 1 |
| mode_r2_i | input | 1 | Rate select bit 2 |
| tx_data_i | input | 1 | Asynchronous transmit data, 1 = mark |
| tone_o | output | 1 | Square-wave FSK tone |
| tx_en_o | output | 1 | High while the transmitter is active |
| ref_clk_o | output | 1 | Bit-rate reference clock, 16x the highest rate |

## Verification
The risky coincidence is a synchronized data edge that swaps the tuning word in the same cycle as the accumulator's top bit crosses, so that a mark/space change meets an output transition. The bench provokes it by flipping data at random intervals in the 1200/2200 Hz mode for many tone periods. It judges the result by the shortest and longest high or low run seen, which must stay inside the half-period bounds of the two tones. A second coincidence is a change of reference divisor while the divider counter is above the new limit. This is covered by mode changes whose reference period must settle to the exact new length.

// File: rtl/fsk_tone_pkg.sv
package fsk_tone_pkg;

  typedef enum logic [2:0] {
    TONE_OFF     = 3'd0,
    TONE_V23_HI  = 3'd1,
    TONE_V23_MID = 3'd2,
    TONE_V23_LO  = 3'd3,
    TONE_B202_HI = 3'd4,
    TONE_B202_LO = 3'd5
  } tone_set_e;

  typedef enum logic [1:0] {
    REF_X1  = 2'd0,
    REF_X2  = 2'd1,
    REF_X8  = 2'd2,
    REF_X16 = 2'd3
  } ref_div_e;

  typedef struct packed {
    tone_set_e tone;
    ref_div_e  refsel;
  } mode_sel_t;

  // Tone frequency in Hz for a tone set code and data value (1 = mark).
  function automatic int unsigned tone_hz(logic [2:0] t, logic mark);
    case (t)
      3'd1:    return mark ? 1300 : 2100;
      3'd2:    return mark ? 1300 : 1700;
      3'd3:    return mark ? 390  : 450;
      3'd4:    return mark ? 1200 : 2200;
      3'd5:    return mark ? 387  : 487;
      default: return 0;
    endcase
  endfunction

  // Rounded phase increment for an accumulator of acc_w bits.
  function automatic logic [63:0] tune_word(int unsigned f, int unsigned clk_hz,
                                            int unsigned acc_w);
    logic [63:0] num;
    num = (64'(f) << acc_w) + 64'(clk_hz / 2);
    return num / 64'(clk_hz);
  endfunction

endpackage

// File: rtl/fsk_std_detect.sv
module fsk_std_detect #(
  parameter int unsigned WIN = 2048
) (
  input  logic clk,
  input  logic rst,
  input  logic std_i,
  output logic level_o,
  output logic clocked_o
);
  localparam int unsigned CW = $clog2(WIN + 1);

  logic [2:0]    sh_q;
  logic [CW-1:0] quiet_q;
  logic          seen_q;
  logic          edge_w;

  assign edge_w  = sh_q[2] ^ sh_q[1];
  assign level_o = sh_q[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q      <= '0;
      quiet_q   <= '0;
      seen_q    <= 1'b0;
      clocked_o <= 1'b0;
    end else begin
      sh_q <= {sh_q[1:0], std_i};
      if (edge_w) begin
        quiet_q <= '0;
        seen_q  <= 1'b1;
        if (seen_q) clocked_o <= 1'b1;
      end else if (quiet_q == CW'(WIN - 1)) begin
        seen_q    <= 1'b0;
        clocked_o <= 1'b0;
      end else begin
        quiet_q <= quiet_q + 1'b1;
      end
    end
  end

  // R8
  clocked_needs_edge_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(clocked_o) |-> $past(sh_q[2]) != $past(sh_q[1]));

endmodule

// File: rtl/fsk_mode_decode.sv
module fsk_mode_decode
  import fsk_tone_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      clocked_i,
  input  logic      level_i,
  input  logic      r1_i,
  input  logic      r2_i,
  output mode_sel_t sel_o
);
  logic [1:0] r1_q, r2_q;
  mode_sel_t  nxt_w;

  always_comb begin
    nxt_w = '{tone: TONE_OFF, refsel: REF_X1};
    casez ({clocked_i, level_i, r1_q[1], r2_q[1]})
      4'b0000, 4'b0100: nxt_w = '{tone: TONE_V23_HI,  refsel: REF_X1};
      4'b0001, 4'b0101: nxt_w = '{tone: TONE_V23_MID, refsel: REF_X2};
      4'b0010:          nxt_w = '{tone: TONE_V23_LO,  refsel: REF_X1};
      4'b0110:          nxt_w = '{tone: TONE_V23_LO,  refsel: REF_X2};
      4'b0011:          nxt_w = '{tone: TONE_V23_LO,  refsel: REF_X16};
      4'b0111:          nxt_w = '{tone: TONE_OFF,     refsel: REF_X1};
      4'b1?0?:          nxt_w = '{tone: TONE_B202_HI, refsel: REF_X1};
      4'b1?10:          nxt_w = '{tone: TONE_B202_LO, refsel: REF_X1};
      4'b1?11:          nxt_w = '{tone: TONE_B202_LO, refsel: REF_X8};
      default:          nxt_w = '{tone: TONE_OFF,     refsel: REF_X1};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      r1_q  <= '0;
      r2_q  <= '0;
      sel_o <= '{tone: TONE_OFF, refsel: REF_X1};
    end else begin
      r1_q  <= {r1_q[0], r1_i};
      r2_q  <= {r2_q[0], r2_i};
      sel_o <= nxt_w;
    end
  end

endmodule

// File: rtl/fsk_phase_acc.sv
module fsk_phase_acc
  import fsk_tone_pkg::*;
#(
  parameter int unsigned CLK_HZ = 4433600,
  parameter int unsigned ACC_W  = 32
) (
  input  logic      clk,
  input  logic      rst,
  input  tone_set_e tone_i,
  input  logic      mark_i,
  output logic      tone_o,
  output logic      en_o
);
  localparam int unsigned LUT_N = 16;

  logic [ACC_W-1:0] tw_lut [LUT_N];
  logic [ACC_W-1:0] tw_q;
  logic [ACC_W-1:0] acc_q;

  for (genvar g = 0; g < LUT_N; g++) begin : g_lut
    localparam int unsigned F_HZ = tone_hz(3'(g / 2), 1'(g % 2));
    assign tw_lut[g] = ACC_W'(tune_word(F_HZ, CLK_HZ, ACC_W));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tw_q   <= '0;
      acc_q  <= '0;
      en_o   <= 1'b0;
      tone_o <= 1'b0;
    end else begin
      tw_q   <= tw_lut[{tone_i, mark_i}];
      en_o   <= (tone_i != TONE_OFF);
      if (en_o) acc_q <= acc_q + tw_q;
      tone_o <= en_o & acc_q[ACC_W-1];
    end
  end

  // R2
  tw_range_chk: assert property (@(posedge clk) disable iff (rst)
    tw_q < (ACC_W'(1) << (ACC_W - 1)));

  // R4
  tx_off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !en_o |=> !tone_o);

endmodule

// File: rtl/fsk_ref_div.sv
module fsk_ref_div
  import fsk_tone_pkg::*;
#(
  parameter int unsigned REF_HALF = 116
) (
  input  logic     clk,
  input  logic     rst,
  input  ref_div_e refsel_i,
  output logic     ref_o
);
  localparam int unsigned HW = $clog2(REF_HALF * 16 + 1);

  logic [HW-1:0] cnt_q;
  logic [HW-1:0] half_w;

  always_comb begin
    case (refsel_i)
      REF_X2:  half_w = HW'(REF_HALF * 2);
      REF_X8:  half_w = HW'(REF_HALF * 8);
      REF_X16: half_w = HW'(REF_HALF * 16);
      default: half_w = HW'(REF_HALF);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ref_o <= 1'b0;
    end else if (cnt_q >= half_w - 1'b1) begin
      cnt_q <= '0;
      ref_o <= ~ref_o;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R5
  ref_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (ref_o != $past(ref_o)) |-> ($past(cnt_q) + 1'b1 >= $past(half_w)));

endmodule

// File: rtl/fsk_tone_synth.sv
module fsk_tone_synth
  import fsk_tone_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 4433600,
  parameter int unsigned ACC_W    = 32,
  parameter int unsigned REF_HALF = 116,
  parameter int unsigned STD_WIN  = 2048
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_std_i,
  input  logic mode_r1_i,
  input  logic mode_r2_i,
  input  logic tx_data_i,
  output logic tone_o,
  output logic tx_en_o,
  output logic ref_clk_o
);
  logic      std_level, std_clocked;
  mode_sel_t sel;
  logic [1:0] dsync_q;

  always_ff @(posedge clk) begin
    if (rst) dsync_q <= '0;
    else     dsync_q <= {dsync_q[0], tx_data_i};
  end

  fsk_std_detect #(.WIN(STD_WIN)) std_det_i (
    .clk(clk), .rst(rst), .std_i(mode_std_i),
    .level_o(std_level), .clocked_o(std_clocked)
  );

  fsk_mode_decode mode_dec_i (
    .clk(clk), .rst(rst), .clocked_i(std_clocked), .level_i(std_level),
    .r1_i(mode_r1_i), .r2_i(mode_r2_i), .sel_o(sel)
  );

  fsk_phase_acc #(.CLK_HZ(CLK_HZ), .ACC_W(ACC_W)) acc_i (
    .clk(clk), .rst(rst), .tone_i(sel.tone), .mark_i(dsync_q[1]),
    .tone_o(tone_o), .en_o(tx_en_o)
  );

  fsk_ref_div #(.REF_HALF(REF_HALF)) ref_i (
    .clk(clk), .rst(rst), .refsel_i(sel.refsel), .ref_o(ref_clk_o)
  );

  // R6
  data_sync_chk: assert property (@(posedge clk) disable iff (rst)
    (dsync_q[1] != $past(dsync_q[1])) |-> (dsync_q[1] == $past(tx_data_i, 2)));

  // R4
  off_low_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_en_o |=> !tone_o);

endmodule

// File: tb/fsk_tone_synth_tb.sv
module fsk_tone_synth_tb_top;
  localparam int unsigned CLK_HZ  = 1108400;
  localparam int unsigned STD_WIN = 2048;
  localparam int unsigned TGL_HALF = 100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic std_lvl = 1'b0, std_tgl = 1'b0, std_clk_en = 1'b0;
  logic r1 = 1'b0, r2 = 1'b0, txd = 1'b0;
  logic mode_std;
  logic tone_o, tx_en_o, ref_clk_o;
  int checks = 0;
  int errors = 0;
  int tgl_cnt = 0;

  always #5 clk = ~clk;
  assign mode_std = std_clk_en ? std_tgl : std_lvl;

  fsk_tone_synth #(.CLK_HZ(CLK_HZ), .STD_WIN(STD_WIN)) dut_i (
    .clk(clk), .rst(rst), .mode_std_i(mode_std), .mode_r1_i(r1),
    .mode_r2_i(r2), .tx_data_i(txd), .tone_o(tone_o), .tx_en_o(tx_en_o),
    .ref_clk_o(ref_clk_o)
  );

  initial forever begin
    @(negedge clk);
    if (std_clk_en) begin
      if (tgl_cnt == TGL_HALF - 1) begin tgl_cnt = 0; std_tgl = ~std_tgl; end
      else tgl_cnt++;
    end
  end

  function automatic int exp_hz(bit clkd, bit s, bit a, bit b, bit d);
    if (clkd) return a ? (d ? 387 : 487) : (d ? 1200 : 2200);
    case ({s, a, b})
      3'b000, 3'b100: return d ? 1300 : 2100;
      3'b001, 3'b101: return d ? 1300 : 1700;
      3'b111:         return 0;
      default:        return d ? 390 : 450;
    endcase
  endfunction

  function automatic int exp_ref(bit clkd, bit s, bit a, bit b);
    if (clkd) return (a && b) ? 1856 : 232;
    case ({s, a, b})
      3'b001, 3'b101, 3'b110: return 464;
      3'b011:                 return 3712;
      default:                return 232;
    endcase
  endfunction

  task automatic check_eq(input string req, input int got, input int expv);
    checks++;
    if (got != expv) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, expv);
    end
  endtask

  task automatic check_tone(input string req, input int hz);
    int cyc, rises, guard;
    logic p;
    real expc, err;
    cyc = 0; rises = 0; guard = 0;
    p = tone_o;
    while (!(tone_o && !p) && guard < 20000) begin
      p = tone_o; @(negedge clk); guard++;
    end
    p = tone_o;
    while (rises < 3 && cyc < 40000) begin
      @(negedge clk); cyc++;
      if (tone_o && !p) rises++;
      p = tone_o;
    end
    expc = 3.0 * real'(CLK_HZ) / real'(hz);
    err = (real'(cyc) - expc) / expc;
    if (err < 0.0) err = -err;
    checks++;
    if (rises < 3 || err > 0.005) begin
      errors++;
      $display("FAIL %s: got %0d cycles for 3 periods expected %0.1f (%0d Hz)",
               req, cyc, expc, hz);
    end
  endtask

  task automatic check_ref(input string req, input int full);
    int cyc, guard;
    logic p;
    cyc = 0; guard = 0;
    p = ref_clk_o;
    while (!(ref_clk_o && !p) && guard < 10000) begin
      p = ref_clk_o; @(negedge clk); guard++;
    end
    p = ref_clk_o;
    while (cyc < 10000) begin
      @(negedge clk); cyc++;
      if (ref_clk_o && !p) break;
      p = ref_clk_o;
    end
    check_eq(req, cyc, full);
  endtask

  task automatic set_level(input bit s, input bit a, input bit b);
    bit chg;
    chg = (std_lvl != s);
    std_lvl = s; r1 = a; r2 = b;
    if (chg) repeat (STD_WIN + 16) @(negedge clk);
    else repeat (16) @(negedge clk);
  endtask

  initial begin
    int seed, runs, run, minr, maxr, left, highs, lo_b, hi_b;
    logic p;
    seed = $urandom(32'h5A17);
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    check_eq("R1 tone", int'(tone_o), 0);
    check_eq("R1 ref", int'(ref_clk_o), 0);
    check_eq("R1 txen", int'(tx_en_o), 0);
    rst = 1'b0;
    @(negedge clk);
    check_eq("R1 tone after release", int'(tone_o), 0);
    repeat (16) @(negedge clk);
    check_eq("R4 txen in 000", int'(tx_en_o), 1);
    // R6: data 1 gives mark, data 0 space, through the synchronizer
    txd = 1'b1; repeat (8) @(negedge clk);
    check_tone("R6 R2 000 mark", exp_hz(0, 0, 0, 0, 1));
    txd = 1'b0; repeat (8) @(negedge clk);
    check_tone("R6 R2 000 space", exp_hz(0, 0, 0, 0, 0));
    check_ref("R5 000", exp_ref(0, 0, 0, 0));
    // R2/R5 random level modes (never 111)
    for (int t = 0; t < 6; t++) begin
      int m;
      bit d;
      m = $urandom_range(0, 6);
      d = 1'($urandom_range(0, 1));
      txd = d;
      set_level(m[2], m[1], m[0]);
      check_tone($sformatf("R2 mode %0d data %0d", m, d),
                 exp_hz(0, m[2], m[1], m[0], d));
      check_ref($sformatf("R5 mode %0d", m), exp_ref(0, m[2], m[1], m[0]));
    end
    // R2 directed slow corner 011
    set_level(0, 1, 1);
    txd = 1'b0; repeat (8) @(negedge clk);
    check_tone("R2 011 space", 450);
    check_ref("R5 011", 3712);
    // R4: disabled mode ignores data
    set_level(1, 1, 1);
    check_eq("R4 txen off", int'(tx_en_o), 0);
    highs = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (i % 37 == 0) txd = ~txd;
      if (tone_o) highs++;
    end
    check_eq("R4 tone held low", highs, 0);
    check_ref("R5 111", 232);
    // R3/R8: toggling select input
    std_tgl = std_lvl; tgl_cnt = 0; std_clk_en = 1'b1;
    r1 = 1'b0; r2 = 1'b0;
    repeat (600) @(negedge clk);
    check_eq("R3 txen bell", int'(tx_en_o), 1);
    txd = 1'b1; repeat (8) @(negedge clk);
    check_tone("R3 R8 bell fast mark", 1200);
    txd = 1'b0; repeat (8) @(negedge clk);
    check_tone("R3 bell fast space", 2200);
    check_ref("R5 toggled 00", 232);
    r1 = 1'b1; r2 = 1'b1; repeat (16) @(negedge clk);
    txd = 1'b1; repeat (8) @(negedge clk);
    check_tone("R3 bell slow mark", 387);
    txd = 1'b0; repeat (8) @(negedge clk);
    check_tone("R3 bell slow space", 487);
    check_ref("R5 toggled 11", 1856);
    // R7: random data flips during 1200/2200 Hz
    r1 = 1'b0; r2 = 1'b0; repeat (16) @(negedge clk);
    lo_b = int'(real'(CLK_HZ) / 4400.0) - 1;
    hi_b = int'(real'(CLK_HZ) / 2400.0 + 0.999) + 1;
    minr = 1 << 30; maxr = 0; runs = 0; run = 0;
    left = $urandom_range(60, 700);
    p = tone_o;
    for (int i = 0; i < 16000; i++) begin
      @(negedge clk);
      left--;
      if (left == 0) begin txd = ~txd; left = $urandom_range(60, 700); end
      if (tone_o != p) begin
        if (runs > 0) begin
          if (run < minr) minr = run;
          if (run > maxr) maxr = run;
        end
        runs++; run = 1;
      end else run++;
      p = tone_o;
    end
    checks++;
    if (minr < lo_b) begin errors++; $display("FAIL R7 shortest run: got %0d expected >= %0d", minr, lo_b); end
    checks++;
    if (maxr > hi_b) begin errors++; $display("FAIL R7 longest run: got %0d expected <= %0d", maxr, hi_b); end
    // R8: stop toggling, hold level 1 -> decodes 100 after the quiet window
    std_clk_en = 1'b0; std_lvl = 1'b1; r1 = 1'b0; r2 = 1'b0; txd = 1'b1;
    repeat (STD_WIN + 64) @(negedge clk);
    check_tone("R8 revert to level 100 mark", 1300);
    check_ref("R8 R5 revert 100", 232);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule